// File: doc/BRIEF.md
# Program Bank Translator for a Cartridge CPU Bus

This block sits between the console CPU bus and the cartridge program ROM. It turns a 16-bit CPU address into a physical ROM address and raises a ROM select or a work-RAM select. Two 8 KiB windows, one at 0x8000 and one at 0xA000, each show a bank chosen by its own register. The upper 16 KiB, from 0xC000 to 0xFFFF, always shows the final two banks of the ROM. The 8 KiB at 0x6000–0x7FFF goes to work RAM.

The CPU changes the bank registers and a one-bit nametable mirroring control by writing to decoded addresses. The mirroring bit steers the video-side nametable address line. The bus has no flow control: an address is held for a cycle and a write strobe qualifies it. For that reason every pin is a plain level signal and there is no valid/ready stream. Address translation is combinational. Register updates land on the rising clock edge.

Top module: `prg_bank_xlat`

## Requirements
- R1: When the active-low reset is applied, both bank registers and the mirroring bit clear to 0. After reset, 0x8000 and 0xA000 both translate to ROM address 0, and nt_a10 follows ppu_a10.
- R2: A write strobed with any address 0x8000–0x8003 loads bank register 0 from cpu_data[4:0]. For addresses 0x8000–0x9FFF, rom_addr = {bank0, cpu_addr[12:0]}.
- R3: A write strobed with any address 0xA000–0xA003 loads bank register 1 from cpu_data[4:0]. For addresses 0xA000–0xBFFF, rom_addr = {bank1, cpu_addr[12:0]}.
- R4: The range 0xC000–0xDFFF maps to bank NUM_BANKS−2 and 0xE000–0xFFFF maps to bank NUM_BANKS−1, whatever the register contents. The low 13 address bits pass through unchanged.
- R5: For 0x6000–0x7FFF, ram_sel is 1, rom_sel is 0 and rom_addr is 0.
- R6: rom_sel is 1 exactly for 0x8000–0xFFFF. Below 0x6000, rom_sel, ram_sel and rom_addr are all 0. rom_sel and ram_sel are never 1 together.
- R7: A write strobed with address exactly 0x9000 sets mirror_horiz from cpu_data[0]. When mirror_horiz is 0, nt_a10 = ppu_a10 (vertical). When it is 1, nt_a10 = ppu_a11 (horizontal).
- R8: Writes to any other address leave both bank registers and the mirroring bit unchanged. Examples are 0x8004, 0x9001, 0xB000 and 0x6000.
- R9: cpu_data bits 7:5 have no effect on a bank register load.
- R10: A register change is visible only after the rising clock edge on which cpu_wr is 1. With cpu_wr at 0, the same address and data change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, qualifies cpu_addr and cpu_data |
| ppu_a10 | input | 1 | Video bus address bit 10 |
| ppu_a11 | input | 1 | Video bus address bit 11 |
| rom_addr | output | BANK_BITS+13 | Physical program ROM address, 0 when ROM is not selected |
| rom_sel | output | 1 | Program ROM select |
| ram_sel | output | 1 | Work RAM select |
| mirror_horiz | output | 1 | Current mirroring mode, 1 means horizontal |
| nt_a10 | output | 1 | Nametable address line 10 |

## Verification
The translation is driven with reads at both edges of every 8 KiB window, so that a bank taken from the wrong register or a wrong fixed bank shows up in the upper address bits. Writes land at the first and last address of each 4-byte register range. Writes also go to the address just past each range and to the mirroring address plus one, which separates an exact decode from a loose one. Bank data with bits 7:5 set exposes a register that keeps too many bits. A read at the written address before and after the clock edge distinguishes a registered update from a combinational pass-through. The nametable output is checked with the two video address bits set to opposite values in each mode, so a swapped mux cannot go unnoticed.

// File: rtl/prg_xlat_pkg.sv
package prg_xlat_pkg;
  localparam int OFS_BITS = 13;
  localparam logic [15:0] BANK0_BASE  = 16'h8000;
  localparam logic [15:0] BANK1_BASE  = 16'hA000;
  localparam logic [15:0] MIRROR_ADDR = 16'h9000;
  localparam logic [2:0]  RAM_PAGE    = 3'b011;
  typedef enum logic [1:0] {WIN_NONE, WIN_RAM, WIN_ROM} win_e;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_xlat_pkg::*;
#(
  parameter int BANK_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_data,
  input  logic                 cpu_wr,
  output logic [BANK_BITS-1:0] bank0_o,
  output logic [BANK_BITS-1:0] bank1_o,
  output logic                 mirror_o
);
  logic [BANK_BITS-1:0] bank_q [2];
  logic                 mirror_q;
  logic                 unused_data_hi;

  assign unused_data_hi = ^cpu_data[7:BANK_BITS];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam logic [15:0] BASE = (g == 0) ? BANK0_BASE : BANK1_BASE;
    logic hit;
    assign hit = cpu_wr && (cpu_addr[15:2] == BASE[15:2]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[g] <= '0;
      else if (hit) bank_q[g] <= cpu_data[BANK_BITS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  mirror_q <= 1'b0;
    else if (cpu_wr && cpu_addr == MIRROR_ADDR)  mirror_q <= cpu_data[0];
  end

  assign bank0_o  = bank_q[0];
  assign bank1_o  = bank_q[1];
  assign mirror_o = mirror_q;

  // R2: a strobed write in the first register range lands one edge later
  a_r2_bank0_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:2] == 14'h2000) |=> bank0_o == $past(cpu_data[BANK_BITS-1:0]));
  // R3
  a_r3_bank1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:2] == 14'h2800) |=> bank1_o == $past(cpu_data[BANK_BITS-1:0]));
  // R10: nothing changes without the strobe
  a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(bank0_o) && $stable(bank1_o) && $stable(mirror_o)));
  // R8: off-target writes keep the bank registers
  a_r8_bank_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:2] != 14'h2000 && cpu_addr[15:2] != 14'h2800)
      |=> ($stable(bank0_o) && $stable(bank1_o)));
  // R7
  a_r7_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h9000) |=> mirror_o == $past(cpu_data[0]));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import prg_xlat_pkg::*;
#(
  parameter int BANK_BITS = 5,
  parameter int NUM_BANKS = 32
) (
  input  logic [15:0]                   cpu_addr,
  input  logic [BANK_BITS-1:0]          bank0,
  input  logic [BANK_BITS-1:0]          bank1,
  output logic [BANK_BITS+OFS_BITS-1:0] rom_addr,
  output logic                          rom_sel,
  output logic                          ram_sel
);
  localparam logic [BANK_BITS-1:0] FIX_LO = BANK_BITS'(NUM_BANKS - 2);
  localparam logic [BANK_BITS-1:0] FIX_HI = BANK_BITS'(NUM_BANKS - 1);

  win_e                 win;
  logic [BANK_BITS-1:0] bank;

  always_comb begin
    if (cpu_addr[15])                          win = WIN_ROM;
    else if (cpu_addr[15:13] == RAM_PAGE)      win = WIN_RAM;
    else                                       win = WIN_NONE;
  end

  always_comb begin
    unique case (cpu_addr[14:13])
      2'b00:   bank = bank0;
      2'b01:   bank = bank1;
      2'b10:   bank = FIX_LO;
      default: bank = FIX_HI;
    endcase
  end

  assign rom_sel  = (win == WIN_ROM);
  assign ram_sel  = (win == WIN_RAM);
  assign rom_addr = rom_sel ? {bank, cpu_addr[OFS_BITS-1:0]} : '0;
endmodule

// File: rtl/nt_mirror_sel.sv
module nt_mirror_sel (
  input  logic horiz,
  input  logic ppu_a10,
  input  logic ppu_a11,
  output logic nt_a10
);
  assign nt_a10 = horiz ? ppu_a11 : ppu_a10;
endmodule

// File: rtl/prg_bank_xlat.sv
module prg_bank_xlat
  import prg_xlat_pkg::*;
#(
  parameter int BANK_BITS = 5,
  parameter int NUM_BANKS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_data,
  input  logic                  cpu_wr,
  input  logic                  ppu_a10,
  input  logic                  ppu_a11,
  output logic [BANK_BITS+12:0] rom_addr,
  output logic                  rom_sel,
  output logic                  ram_sel,
  output logic                  mirror_horiz,
  output logic                  nt_a10
);
  logic [BANK_BITS-1:0] bank0, bank1;

  prg_bank_regs #(.BANK_BITS(BANK_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .bank0_o(bank0), .bank1_o(bank1), .mirror_o(mirror_horiz)
  );

  prg_addr_map #(.BANK_BITS(BANK_BITS), .NUM_BANKS(NUM_BANKS)) u_map (
    .cpu_addr(cpu_addr), .bank0(bank0), .bank1(bank1),
    .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_sel(ram_sel)
  );

  nt_mirror_sel u_nt (
    .horiz(mirror_horiz), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .nt_a10(nt_a10)
  );

  // R6: the two selects never overlap
  a_r6_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel}));
  // R5: the work-RAM window never drives a ROM address
  a_r5_ram_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (rom_addr == '0 && cpu_addr[15:13] == 3'b011));
  // R4: the upper half of ROM space shows the last two banks
  a_r4_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && cpu_addr[14]) |-> (32'(rom_addr[BANK_BITS+12:13]) == 32'(NUM_BANKS - 2) + 32'(cpu_addr[13])));
  // R7: nametable line follows the mode
  a_r7_nt_follow: assert property (@(posedge clk) disable iff (!rst_n)
    nt_a10 == (mirror_horiz ? ppu_a11 : ppu_a10));
endmodule

// File: tb/prg_bank_xlat_bench.sv
module prg_bank_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic        ppu_a10 = 1'b0;
  logic        ppu_a11 = 1'b0;
  logic [17:0] rom_addr;
  logic        rom_sel, ram_sel, mirror_horiz, nt_a10;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  prg_bank_xlat u_prg_bank_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
    .mirror_horiz(mirror_horiz), .nt_a10(nt_a10)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] waddr;
    logic [7:0]  wdata;
    logic [15:0] raddr;
    logic [17:0] rom;
    logic        rs;
    logic        ms;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h8000, 8'h05, 16'h8000, 18'h0A000, 1'b1, 1'b0, 8'd2},  // R2 low edge
    '{1'b1, 16'h8003, 8'h1F, 16'h9FFF, 18'h3FFFF, 1'b1, 1'b0, 8'd2},  // R2 top of range
    '{1'b1, 16'hA002, 8'hE3, 16'hA123, 18'h06123, 1'b1, 1'b0, 8'd9},  // R9, R3
    '{1'b1, 16'h8004, 8'h07, 16'h8010, 18'h3E010, 1'b1, 1'b0, 8'd8},  // R8 past range
    '{1'b0, 16'hA000, 8'h0A, 16'hA000, 18'h06000, 1'b1, 1'b0, 8'd10}, // R10 no strobe
    '{1'b0, 16'h0000, 8'h00, 16'hC000, 18'h3C000, 1'b1, 1'b0, 8'd4},  // R4
    '{1'b0, 16'h0000, 8'h00, 16'hDFFF, 18'h3DFFF, 1'b1, 1'b0, 8'd4},  // R4
    '{1'b0, 16'h0000, 8'h00, 16'hE000, 18'h3E000, 1'b1, 1'b0, 8'd4},  // R4
    '{1'b0, 16'h0000, 8'h00, 16'hFFFF, 18'h3FFFF, 1'b1, 1'b0, 8'd4},  // R4
    '{1'b1, 16'h6000, 8'h00, 16'h6000, 18'h00000, 1'b0, 1'b1, 8'd5},  // R5
    '{1'b1, 16'h7FFF, 8'h01, 16'h7FFF, 18'h00000, 1'b0, 1'b1, 8'd5},  // R5
    '{1'b1, 16'hB000, 8'h00, 16'hA000, 18'h06000, 1'b1, 1'b0, 8'd8},  // R8
    '{1'b0, 16'h0000, 8'h00, 16'h5FFF, 18'h00000, 1'b0, 1'b0, 8'd6},  // R6
    '{1'b0, 16'h0000, 8'h00, 16'h4020, 18'h00000, 1'b0, 1'b0, 8'd6},  // R6
    '{1'b1, 16'hA001, 8'h00, 16'hBFFF, 18'h01FFF, 1'b1, 1'b0, 8'd3},  // R3
    '{1'b1, 16'h8002, 8'h10, 16'h8ABC, 18'h20ABC, 1'b1, 1'b0, 8'd2},  // R2
    '{1'b1, 16'h9000, 8'h1F, 16'h8ABC, 18'h20ABC, 1'b1, 1'b0, 8'd8}   // R8 mirror write
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = w;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a,
                          input logic [17:0] erom, input logic ers, input logic ems);
    cpu_addr = a;
    #1;
    chk(req, {rom_addr, rom_sel, ram_sel}, {erom, ers, ems});
  endtask

  task automatic nt_chk(input string req, input logic a10, input logic a11, input logic exp);
    ppu_a10 = a10; ppu_a11 = a11;
    #1;
    chk(req, {19'd0, nt_a10}, {19'd0, exp});
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    read_chk("R1", 16'h8000, 18'h00000, 1'b1, 1'b0);
    read_chk("R1", 16'hA000, 18'h00000, 1'b1, 1'b0);
    nt_chk("R1", 1'b1, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i].waddr, VEC[i].wdata, VEC[i].wr);
      read_chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].raddr,
               VEC[i].rom, VEC[i].rs, VEC[i].ms);
    end

    // R10: update shows only after the edge
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h03; cpu_wr = 1'b1;
    #1;
    chk("R10 before edge", {rom_addr, rom_sel, ram_sel}, {18'h20000, 1'b1, 1'b0});
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    chk("R10 after edge", {rom_addr, rom_sel, ram_sel}, {18'h06000, 1'b1, 1'b0});

    // R7: last vector wrote 0x9000 with bit0 = 1 -> horizontal
    nt_chk("R7 horiz", 1'b0, 1'b1, 1'b1);
    nt_chk("R7 horiz", 1'b1, 1'b0, 1'b0);
    bus_write(16'h9001, 8'h00, 1'b1);
    nt_chk("R8 9001 ignored", 1'b0, 1'b1, 1'b1);
    bus_write(16'h9000, 8'hFE, 1'b1);
    nt_chk("R7 vert", 1'b1, 1'b0, 1'b1);
    nt_chk("R7 vert", 1'b0, 1'b1, 1'b0);

    // R1: reset in mid-run clears everything
    bus_write(16'hA000, 8'h0C, 1'b1);
    bus_write(16'h9000, 8'h01, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk("R1 again", 16'h8000, 18'h00000, 1'b1, 1'b0);
    read_chk("R1 again", 16'hA000, 18'h00000, 1'b1, 1'b0);
    nt_chk("R1 again", 1'b0, 1'b1, 1'b0);

    done = 1;
    finish_up();
  end
endmodule